// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block connects a simple single-cycle request port on the system clock to an external asynchronous static RAM. The RAM holds 1,048,576 nibbles, which gives a 20-bit address and 4-bit data. The controller drives the active-low chip-select, output-gate and write-strobe pins from registers, so they cannot glitch. It drives the shared data lines only while it writes, and it samples read data on a clock edge. Every analog timing limit is given in picoseconds. Each limit is turned into a whole number of clock cycles, rounded up, from a clock-period parameter whose default is 10 ns.

A host starts an access by raising `req` for one cycle together with the direction, address and write nibble. The block answers with a one-cycle `done`, and `rd_data` is valid in that same cycle for a read. After reset the block waits out a power-up interval before it accepts any access. A retention request parks the memory deselected. When the request is released, the block waits out a recovery interval. Any request that arrives during these waits, or while an access is running, is dropped.

The data bus is split into `mem_dq_out`, `mem_dq_oe` and `mem_dq_in`, so that the pad ring can build the three-state buffer.

Top module: `sram_ctl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `mem_ce_n`, `mem_oe_n` and `mem_we_n` high, `mem_dq_oe` low and `done` low.
- R2: After reset is released, `mem_ce_n` stays high for at least PWR_C = ceil(1 µs / clock) cycles (100 at 10 ns), and no request is accepted before that.
- R3: A write holds `mem_we_n` low for WLOW_C = max(ceil(8 ns), ceil(6 ns)+ceil(6 ns)) cycles (2 at 10 ns), with `mem_ce_n` and `mem_oe_n` low and `mem_addr` steady. The write nibble is driven from HZ_C = ceil(6 ns) cycles after the strobe falls until the edge where it rises, so that at least ceil(6 ns) cycles of setup come before that edge. The addressed location then holds the nibble.
- R4: `mem_dq_oe` is high only while `mem_ce_n` and `mem_we_n` are both low. The bus is released on the edge where `mem_we_n` rises.
- R5: A read holds `mem_ce_n` and `mem_oe_n` low and `mem_we_n` high for RD_C = max(ceil(12 ns), ceil(12 ns)) cycles (2 at 10 ns). `mem_dq_in` is sampled on the last edge of that window and appears on `rd_data` with `done`.
- R6: Each accepted access produces exactly one `done` pulse, which lasts one cycle. It follows the accepting edge by WLOW_C/RD_C edges (at least the 12 ns write cycle).
- R7: A `req` seen while an access is running, or during the power-up, retention or recovery waits, has no effect on the memory pins or on the memory contents.
- R8: `mem_ce_n` stays low from one access to the next when the host raises `req` in the idle cycle right after `done`. It rises in the first idle cycle with no request. `mem_oe_n` always equals `mem_ce_n` outside a write.
- R9: When `ret_req` is high in an idle cycle, `mem_ce_n` goes high and stays high while `ret_req` is held. After `ret_req` falls, no access starts for REC_C = ceil(200 µs / clock) cycles (20000 at 10 ns).
- R10: When `ret_req` and `req` are both high in the same idle cycle, retention wins and the request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | One-cycle access request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 4 | Write nibble |
| ret_req | input | 1 | Hold memory deselected for retention |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 4 | Read nibble, valid with `done` after a read |
| mem_addr | output | 20 | Registered address to the RAM |
| mem_ce_n | output | 1 | Active-low chip select |
| mem_oe_n | output | 1 | Active-low output gate |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_dq_out | output | 4 | Data to drive onto the bus |
| mem_dq_oe | output | 1 | Bus drive enable |
| mem_dq_in | input | 4 | Data sensed from the bus |

## Verification
The assertions observe only the memory-side pins and `done`. They assume that reset is applied at the start, because the power-up window is counted from reset release. They also assume that the host raises `req` only as a single-cycle pulse. The bench drives every request for exactly one cycle and holds `ret_req` steady for many cycles at a time. It answers reads from a behavioural RAM that drives `mem_dq_in` only while the pins select a read. Requests during busy, power-up, retention and recovery intervals are deliberate. The bench checks them through later read-back and does not treat them as legal accesses.

// File: rtl/sram_ctl_pkg.sv
// Package: shared state type and cycle-rounding helpers for the SRAM controller.
// Assumes all times are given in picoseconds as positive integers.
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_PWR,
        ST_IDLE,
        ST_WR,
        ST_RD,
        ST_RET,
        ST_REC
    } seq_state_t;

    // Round a time up to whole clock cycles, never below one cycle.
    function automatic int unsigned cyc_of(input int unsigned t_ps, input int unsigned clk_ps);
        int unsigned c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned imax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctl_wait.sv
// Module: down-counting wait timer used for power-up and recovery intervals.
// Loads RST_VAL in reset, reloads on load, counts to zero and holds there.
module sram_ctl_wait #(
    parameter int W       = 16,
    parameter int RST_VAL = 100
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    // Count down toward zero; reset starts the power-up interval.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= W'(RST_VAL);
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/sram_ctl_seq.sv
// Module: access sequencer. It owns the strobes, the bus-drive enable and the done pulse.
// Assumes req is a single-cycle pulse; it samples requests only in the idle state.
module sram_ctl_seq
    import sram_ctl_pkg::*;
#(
    parameter int HZ_C   = 1,
    parameter int WLOW_C = 2,
    parameter int WTOT_C = 2,
    parameter int RD_C   = 2,
    parameter int REC_C  = 20000,
    parameter int PW     = 2,
    parameter int TW     = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_wr,
    input  logic          ret_req,
    input  logic          tmr_zero,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_val,
    output logic          accept,
    output logic          capture,
    output logic          done,
    output logic          ce_n,
    output logic          oe_n,
    output logic          we_n,
    output logic          dq_oe
);
    localparam logic [PW-1:0] HZ_END  = PW'(HZ_C - 1);
    localparam logic [PW-1:0] LOW_END = PW'(WLOW_C - 1);
    localparam logic [PW-1:0] WR_END  = PW'(WTOT_C - 1);
    localparam logic [PW-1:0] RD_END  = PW'(RD_C - 1);

    seq_state_t    state;
    logic [PW-1:0] ph;

    // Decode the handshake points that the datapath and timer use.
    always_comb begin
        accept   = (state == ST_IDLE) && !ret_req && req;
        capture  = (state == ST_RD) && (ph == RD_END);
        tmr_load = (state == ST_RET) && !ret_req;
        tmr_val  = TW'(REC_C);
    end

    // Step the state, the phase counter and the registered strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_PWR;
            ph    <= '0;
            done  <= 1'b0;
            ce_n  <= 1'b1;
            oe_n  <= 1'b1;
            we_n  <= 1'b1;
            dq_oe <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_PWR: if (tmr_zero) state <= ST_IDLE;
                ST_IDLE: begin
                    if (ret_req) begin
                        ce_n  <= 1'b1;
                        oe_n  <= 1'b1;
                        state <= ST_RET;
                    end else if (req) begin
                        ce_n  <= 1'b0;
                        oe_n  <= 1'b0;
                        we_n  <= !req_wr;
                        ph    <= '0;
                        state <= req_wr ? ST_WR : ST_RD;
                    end else begin
                        ce_n <= 1'b1;
                        oe_n <= 1'b1;
                    end
                end
                ST_WR: begin
                    ph <= ph + 1'b1;
                    if (ph == HZ_END) dq_oe <= 1'b1;
                    if (ph == LOW_END) begin
                        we_n  <= 1'b1;
                        dq_oe <= 1'b0;
                    end
                    if (ph == WR_END) begin
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                ST_RD: begin
                    ph <= ph + 1'b1;
                    if (ph == RD_END) begin
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                ST_RET: if (!ret_req) state <= ST_REC;
                ST_REC: if (tmr_zero) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sram_ctl_dp.sv
// Module: address, write-data and read-capture registers.
// Assumes accept and capture never coincide.
module sram_ctl_dp #(
    parameter int AW = 20,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          capture,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] mem_dq_in,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dq_out,
    output logic [DW-1:0] rd_data
);
    // Latch the request fields when an access is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
        end else if (accept) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
        end
    end

    // Sample the bus on the final edge of a read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (capture)
            rd_data <= mem_dq_in;
    end
endmodule

// File: rtl/sram_ctl.sv
// Module: top of the asynchronous SRAM controller.
// Converts picosecond limits into cycle counts and wires the timer, sequencer and datapath together.
// Assumes a single-cycle req pulse and a clock period of CLK_PS.
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int AW        = 20,
    parameter int DW        = 4,
    parameter int CLK_PS    = 10000,
    parameter int T_AA_PS   = 12000,
    parameter int T_RC_PS   = 12000,
    parameter int T_PWE_PS  = 8000,
    parameter int T_SD_PS   = 6000,
    parameter int T_HZWE_PS = 6000,
    parameter int T_WC_PS   = 12000,
    parameter int T_PWR_PS  = 1000000,
    parameter int T_REC_PS  = 200000000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_wr,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          ret_req,
    output logic          done,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] mem_addr,
    output logic          mem_ce_n,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_in
);
    localparam int HZ_C   = cyc_of(T_HZWE_PS, CLK_PS);
    localparam int SD_C   = cyc_of(T_SD_PS, CLK_PS);
    localparam int PWE_C  = cyc_of(T_PWE_PS, CLK_PS);
    localparam int WC_C   = cyc_of(T_WC_PS, CLK_PS);
    localparam int AA_C   = cyc_of(T_AA_PS, CLK_PS);
    localparam int RC_C   = cyc_of(T_RC_PS, CLK_PS);
    localparam int PWR_C  = cyc_of(T_PWR_PS, CLK_PS);
    localparam int REC_C  = cyc_of(T_REC_PS, CLK_PS);
    localparam int WLOW_C = imax(PWE_C, HZ_C + SD_C);
    localparam int WTOT_C = imax(WLOW_C, WC_C);
    localparam int RD_C   = imax(AA_C, RC_C);
    localparam int TW     = $clog2(imax(PWR_C, REC_C) + 1);
    localparam int PW     = $clog2(imax(WTOT_C, RD_C) + 1);

    logic          accept, capture, tmr_load, tmr_zero;
    logic [TW-1:0] tmr_val;

    sram_ctl_wait #(.W(TW), .RST_VAL(PWR_C)) u_wait (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
    );

    sram_ctl_seq #(
        .HZ_C(HZ_C), .WLOW_C(WLOW_C), .WTOT_C(WTOT_C), .RD_C(RD_C),
        .REC_C(REC_C), .PW(PW), .TW(TW)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .ret_req(ret_req),
        .tmr_zero(tmr_zero), .tmr_load(tmr_load), .tmr_val(tmr_val),
        .accept(accept), .capture(capture), .done(done),
        .ce_n(mem_ce_n), .oe_n(mem_oe_n), .we_n(mem_we_n), .dq_oe(mem_dq_oe)
    );

    sram_ctl_dp #(.AW(AW), .DW(DW)) u_dp (
        .clk(clk), .rst_n(rst_n), .accept(accept), .capture(capture),
        .req_addr(req_addr), .req_wdata(req_wdata), .mem_dq_in(mem_dq_in),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .rd_data(rd_data)
    );
endmodule

// File: rtl/sram_ctl_chk.sv
// Module: protocol checker for the memory-side pins, attached to sram_ctl by bind.
// Assumes reset is applied at start-up; windows are measured with counters, not deep $past.
module sram_ctl_chk #(
    parameter int AW     = 20,
    parameter int DW     = 4,
    parameter int PWR_C  = 100,
    parameter int WLOW_C = 2,
    parameter int SD_C   = 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          done,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ce_n,
    input logic          mem_oe_n,
    input logic          mem_we_n,
    input logic [DW-1:0] mem_dq_out,
    input logic          mem_dq_oe
);
    int unsigned since_rst, we_lo, drv;

    // Track cycles since reset, strobe-low length and drive length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= 0;
            we_lo     <= 0;
            drv       <= 0;
        end else begin
            if (since_rst <= PWR_C) since_rst <= since_rst + 1;
            we_lo <= mem_we_n ? 0 : we_lo + 1;
            drv   <= mem_dq_oe ? drv + 1 : 0;
        end
    end

    p_quiet_powerup_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < PWR_C) |-> mem_ce_n);
    p_we_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_lo >= WLOW_C));
    p_data_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (drv >= SD_C));
    p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr));
    p_data_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));
    p_drive_in_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_we_n && !mem_ce_n));
    p_release_at_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> !mem_dq_oe);
    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_oe_follows_ce_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce_n |-> mem_oe_n);
    p_we_needs_ce_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_ce_n);
endmodule

bind sram_ctl sram_ctl_chk #(
    .AW(AW), .DW(DW), .PWR_C(PWR_C), .WLOW_C(WLOW_C), .SD_C(SD_C)
) u_chk (
    .clk(clk), .rst_n(rst_n), .done(done), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe)
);

// File: tb/test_sram_ctl.sv
// Bench: behavioural per-cycle model of the expected pins, a behavioural RAM and host read-back.
module test_sram_ctl;
    localparam int CLK_NS = 10;
    function automatic int ceil_ns(input int t);
        return (t + CLK_NS - 1) / CLK_NS;
    endfunction
    localparam int HZ    = (6 + CLK_NS - 1) / CLK_NS;
    localparam int WLOW  = ((8 + CLK_NS - 1) / CLK_NS > 2 * HZ) ? (8 + CLK_NS - 1) / CLK_NS : 2 * HZ;
    localparam int WTOT  = (WLOW > (12 + CLK_NS - 1) / CLK_NS) ? WLOW : (12 + CLK_NS - 1) / CLK_NS;
    localparam int RD    = (12 + CLK_NS - 1) / CLK_NS;
    localparam int PWR_C = 1000 / CLK_NS;
    localparam int REC_C = 200000 / CLK_NS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, req_wr = 1'b0, ret_req = 1'b0;
    logic [19:0] req_addr = '0;
    logic [3:0]  req_wdata = '0;
    logic        done, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [3:0]  rd_data, mem_dq_out;
    logic [3:0]  mem_dq_in = '0;
    logic [19:0] mem_addr;

    sram_ctl i_sram_ctl (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_addr(req_addr),
        .req_wdata(req_wdata), .ret_req(ret_req), .done(done), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    always #5 clk = ~clk;

    int checks = 0, fails = 0, cyc = 0;
    bit ended = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural RAM: stores on the rising write strobe, answers reads between clock edges.
    logic [3:0] smem [bit [19:0]];
    logic [3:0] hmem [bit [19:0]];
    always @(posedge mem_we_n) if (!mem_ce_n && rst_n) smem[mem_addr] = mem_dq_out;
    always @(negedge clk) begin
        if (!mem_ce_n && !mem_oe_n && mem_we_n)
            mem_dq_in <= smem.exists(mem_addr) ? smem[mem_addr] : 4'h0;
        else
            mem_dq_in <= 4'h0;
    end

    // Per-cycle expectation of the pins, built from the requirement text.
    localparam int M_PWR = 0, M_IDLE = 1, M_WR = 2, M_RD = 3, M_RET = 4, M_REC = 5;
    int md = M_PWR, mc = 0;
    bit started = 0;
    logic e_ce = 1, e_oe = 1, e_we = 1, e_drv = 0, e_done = 0;
    logic [19:0] e_addr = '0;
    logic [3:0]  e_wd = '0;

    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            md = M_PWR; mc = 0;
            e_ce = 1; e_oe = 1; e_we = 1; e_drv = 0; e_done = 0;
        end else begin
            e_done = 0;
            case (md)
                M_PWR: if (mc == PWR_C) md = M_IDLE; else mc++;
                M_IDLE: begin
                    if (ret_req) begin e_ce = 1; e_oe = 1; md = M_RET; end
                    else if (req) begin
                        e_ce = 0; e_oe = 0; e_we = !req_wr;
                        e_addr = req_addr; e_wd = req_wdata;
                        md = req_wr ? M_WR : M_RD; mc = 0;
                    end else begin e_ce = 1; e_oe = 1; end
                end
                M_WR: begin
                    mc++;
                    if (mc == HZ) e_drv = 1;
                    if (mc == WLOW) begin e_we = 1; e_drv = 0; end
                    if (mc == WTOT) begin e_done = 1; md = M_IDLE; end
                end
                M_RD: begin
                    mc++;
                    if (mc == RD) begin e_done = 1; md = M_IDLE; end
                end
                M_RET: if (!ret_req) begin md = M_REC; mc = 0; end
                M_REC: if (mc == REC_C) md = M_IDLE; else mc++;
                default: md = M_IDLE;
            endcase
        end
    end

    // Compare every output with the model between edges.
    always @(negedge clk) begin
        string ctag;
        if (started && !ended) begin
            if (!rst_n) begin
                chk(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes high in reset", {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
                chk(!mem_dq_oe && !done, "R1 bus released, done low in reset", {mem_dq_oe, done}, 0);
            end else begin
                ctag = (md == M_PWR) ? "R2 select during power-up" :
                       (md == M_RET || md == M_REC) ? "R9 select during retention/recovery" : "R8 select";
                chk(mem_ce_n == e_ce, ctag, mem_ce_n, e_ce);
                chk(mem_oe_n == e_oe, "R8 output gate", mem_oe_n, e_oe);
                chk(mem_we_n == e_we, "R3 write strobe", mem_we_n, e_we);
                chk(mem_dq_oe == e_drv, "R4 bus drive enable", mem_dq_oe, e_drv);
                chk(done == e_done, "R6 done pulse", done, e_done);
                if (!e_ce) chk(mem_addr == e_addr, "R3 address", mem_addr, e_addr);
                if (e_drv) chk(mem_dq_out == e_wd, "R3 write data", mem_dq_out, e_wd);
            end
        end
    end

    // One host access; optionally pokes a second request while busy.
    task automatic access(input bit wr, input logic [19:0] a, input logic [3:0] d,
                          input bit poke, input string tag);
        int n = 0;
        logic [3:0] exp;
        req = 1; req_wr = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        if (poke) begin
            req = 1; req_wr = 1; req_addr = a ^ 20'h00001; req_wdata = ~d;
            @(negedge clk);
        end
        req = 0;
        while (!done && n < 40) begin @(negedge clk); n++; end
        chk(done, "R6 done arrives", done, 1);
        if (wr) begin
            hmem[a] = d;
            chk(smem.exists(a) && smem[a] == d, "R3 memory holds written nibble",
                smem.exists(a) ? smem[a] : 0, d);
        end else begin
            exp = hmem.exists(a) ? hmem[a] : 4'h0;
            chk(rd_data == exp, tag, rd_data, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        rst_n = 0;
        idle(4);
        @(negedge clk) rst_n = 1;
        idle(20);
        // R7: request during the power-up wait is dropped.
        req = 1; req_wr = 1; req_addr = 20'h00007; req_wdata = 4'hF;
        @(negedge clk) req = 0;
        idle(PWR_C);
        access(0, 20'h00007, 4'h0, 0, "R7 power-up request dropped (read-back 0)");
        idle(3);
        // R3/R5/R8: back-to-back writes and reads, edge addresses.
        access(1, 20'h00000, 4'hA, 0, "R3");
        access(1, 20'hFFFFF, 4'h5, 0, "R3");
        access(1, 20'h12345, 4'h3, 0, "R3");
        access(0, 20'h00000, 4'h0, 0, "R5 read lowest address");
        access(0, 20'hFFFFF, 4'h0, 0, "R5 read highest address");
        access(1, 20'h12345, 4'hC, 0, "R3");
        access(0, 20'h12345, 4'h0, 0, "R5 read after overwrite");
        idle(2);
        chk(mem_ce_n, "R8 deselected when host idle", mem_ce_n, 1);
        for (int i = 0; i < 8; i++) access(1, 20'(i * 20'h1F0F1), 4'(i * 3 + 1), 0, "R3");
        for (int i = 0; i < 8; i++) begin
            access(0, 20'(i * 20'h1F0F1), 4'h0, 0, "R5 pattern read-back");
            idle(i % 3);
        end
        // R7: requests poked while busy are dropped.
        access(1, 20'h00100, 4'h6, 1, "R7");
        access(0, 20'h00101, 4'h0, 0, "R7 busy-write dropped (read-back)");
        access(0, 20'h00100, 4'h0, 1, "R5 read with poke");
        access(0, 20'h00101, 4'h0, 0, "R7 busy-write during read dropped");
        idle(3);
        // R10: retention and request in the same idle cycle.
        ret_req = 1; req = 1; req_wr = 1; req_addr = 20'h00100; req_wdata = 4'h9;
        @(negedge clk) req = 0;
        chk(mem_ce_n, "R10 retention wins over request", mem_ce_n, 1);
        idle(30);
        chk(mem_ce_n, "R9 deselected while retention held", mem_ce_n, 1);
        ret_req = 0;
        idle(REC_C / 2);
        // R7/R9: request in recovery is dropped.
        req = 1; req_wr = 1; req_addr = 20'h00100; req_wdata = 4'h2;
        @(negedge clk) req = 0;
        idle(REC_C / 2 + 5);
        access(0, 20'h00100, 4'h0, 0, "R10 request with retention dropped (read-back)");
        access(1, 20'h00200, 4'hE, 0, "R9");
        access(0, 20'h00200, 4'hE, 0, "R9 access after recovery");
        idle(4);
        ended = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: ends a hung run as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !ended) begin
            ended = 1;
            checks++; fails++;
            $display("FAIL watchdog R6 actual=%0d expected=%0d", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule